// File: doc/BRIEF.md
# Sensor Node Duty-Cycle Controller

This block sequences a battery-powered sensor node through its operating states. A periodic wake tick takes it out of its rest state into a sensing phase. In that phase it starts one analog-to-digital conversion and waits for the converter to return a byte. Each byte goes into a sample buffer. When the buffer holds a full payload of samples, the controller hands a frame to the radio and holds a transmit request until the radio reports completion. When fewer samples are buffered, it goes back to sleep or to idle listening, as a configuration bit selects.

While idle, the controller also services receive interrupts from the radio. A frame addressed to this node is consumed. A frame addressed to any other node is passed back to the radio for forwarding. Transmissions can run back to back whenever another full payload has built up, and wake ticks that arrive while the node is busy are remembered until it next rests. A state code on the ports lets the transition trace be followed.

Top module: `node_duty_ctrl`

## Requirements
- R1: After reset the state code is SLEEP. The state encoding is SLEEP=0, IDLE=1, SENSING=2, TX=3, RX=4, and no other code ever appears.
- R2: A wake tick in SLEEP or IDLE moves the controller to SENSING. `adc_start_o` is high for exactly the first cycle spent in SENSING.
- R3: When the conversion result arrives in SENSING, it is stored. If fewer than `cfg_payload_i` samples are then buffered, the next state is IDLE when `cfg_idle_i`=1 and SLEEP when it is 0.
- R4: When a stored sample brings the buffer to `cfg_payload_i` samples, the next state is TX. The frame on `tx_frame_o` holds the buffered samples with the oldest at bits [7:0], and `tx_len_o` equals the payload size. The buffer count returns to zero.
- R5: TX is held, with `tx_req_o` high, until `tx_done_i` is seen.
- R6: On `tx_done_i`, the controller stays in TX and loads a new frame if a full payload is buffered. Otherwise it goes to the rest state selected by `cfg_idle_i`.
- R7: In IDLE, `rx_irq_i` (with no wake pending) moves the controller to RX. In SLEEP, `rx_irq_i` has no effect.
- R8: RX lasts one cycle. When the captured destination equals `cfg_node_addr_i`, the frame is consumed and the rest state follows. Otherwise the controller enters TX with `fwd_req_o` high and `fwd_dest_o` carrying the destination until `tx_done_i`.
- R9: A sample that arrives in any state while the buffer already holds a full payload discards the oldest sample and keeps the newest.
- R10: A wake tick that arrives in SENSING, TX or RX is latched. The latch moves the controller from the next SLEEP or IDLE into SENSING one cycle later.
- R11: `sleep_en_o` is high exactly while the state is SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_tick_i | input | 1 | Periodic wake event, one-cycle pulse |
| adc_done_i | input | 1 | Conversion result valid, one-cycle pulse |
| adc_data_i | input | SAMPLE_W | Conversion result |
| tx_done_i | input | 1 | Radio finished the current transmission |
| rx_irq_i | input | 1 | Radio received a frame |
| rx_dest_i | input | ADDR_W | Destination address of the received frame |
| cfg_node_addr_i | input | ADDR_W | This node's address |
| cfg_payload_i | input | CNT_W | Samples per frame, 1 to MAX_PAYLOAD |
| cfg_idle_i | input | 1 | Rest policy: 1 = IDLE, 0 = SLEEP |
| state_o | output | 3 | Current state code |
| adc_start_o | output | 1 | Start one conversion |
| tx_req_o | output | 1 | Transmit request |
| tx_frame_o | output | MAX_PAYLOAD*SAMPLE_W | Frame bytes, oldest sample lowest |
| tx_len_o | output | CNT_W | Number of valid frame bytes |
| fwd_req_o | output | 1 | Current transmission forwards a received frame |
| fwd_dest_o | output | ADDR_W | Destination of the forwarded frame |
| sleep_en_o | output | 1 | Node may enter low-power sleep |

## Verification
The assertions take for granted that `tx_done_i` and `adc_done_i` are one-cycle pulses and that `cfg_payload_i` stays between 1 and MAX_PAYLOAD. They also assume the payload size does not change while samples are buffered. The stimulus follows these rules. The payload size is fixed for the whole run, while `cfg_idle_i` is changed only between transactions. Completion pulses arrive only a few cycles after the request they answer, and extra samples are fed during a transmission to exercise the overwrite path.

// File: rtl/node_duty_pkg.sv
// Shared types for the sensor node duty-cycle controller.
// Assumes: state codes are visible at the top-level port and must not change.
package node_duty_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_IDLE  = 3'd1,
        ST_SENSE = 3'd2,
        ST_TX    = 3'd3,
        ST_RX    = 3'd4
    } node_state_e;

endpackage

// File: rtl/node_sample_buf.sv
// Sample buffer: a shift register of MAX_PAYLOAD bytes with a saturating count.
// A stored byte enters at slot 0. Once payload_i bytes are held, further stores
// push the oldest out of the counted window. The buffer presents the frame window
// and the full flag as they will be after this cycle's store, so a frame can be
// taken in the same cycle as the sample that completes it.
// Assumes: payload_i lies in 1..MAX_PAYLOAD.
module node_sample_buf #(
    parameter int MAX_PAYLOAD = 32,
    parameter int SAMPLE_W    = 8,
    localparam int CNT_W      = $clog2(MAX_PAYLOAD + 1),
    localparam int IDX_W      = (MAX_PAYLOAD > 1) ? $clog2(MAX_PAYLOAD) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            store_i,
    input  logic [SAMPLE_W-1:0]             data_i,
    input  logic                            take_i,
    input  logic [CNT_W-1:0]                payload_i,
    output logic                            full_pre_o,
    output logic [MAX_PAYLOAD*SAMPLE_W-1:0] win_o
);

    logic [SAMPLE_W-1:0] shreg_q [MAX_PAYLOAD];
    logic [SAMPLE_W-1:0] shreg_d [MAX_PAYLOAD];
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    cnt_pre;

    // Next shift-register contents after an optional store.
    always_comb begin
        for (int i = 0; i < MAX_PAYLOAD; i++) begin
            shreg_d[i] = shreg_q[i];
        end
        if (store_i) begin
            for (int i = MAX_PAYLOAD - 1; i > 0; i--) begin
                shreg_d[i] = shreg_q[i-1];
            end
            shreg_d[0] = data_i;
        end
    end

    // Count after the store, saturating at the payload size.
    always_comb begin
        cnt_pre = cnt_q;
        if (store_i) begin
            cnt_pre = (cnt_q >= payload_i) ? payload_i : cnt_q + CNT_W'(1);
        end
    end

    assign full_pre_o = (cnt_pre >= payload_i);

    // Frame window: byte k is the k-th oldest of the last payload_i samples.
    always_comb begin
        win_o = '0;
        for (int k = 0; k < MAX_PAYLOAD; k++) begin
            if (CNT_W'(k) < payload_i) begin
                win_o[k*SAMPLE_W +: SAMPLE_W] =
                    shreg_d[IDX_W'(payload_i - CNT_W'(1) - CNT_W'(k))];
            end
        end
    end

    // Register the shifted samples and the count, which clears when a frame is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < MAX_PAYLOAD; i++) begin
                shreg_q[i] <= '0;
            end
        end else begin
            cnt_q <= take_i ? '0 : cnt_pre;
            for (int i = 0; i < MAX_PAYLOAD; i++) begin
                shreg_q[i] <= shreg_d[i];
            end
        end
    end

endmodule

// File: rtl/node_seq_fsm.sv
// Node sequencer: the SLEEP/IDLE/SENSING/TX/RX state machine.
// It also holds the wake latch, the captured receive destination and the forward flag.
// take_o tells the buffer and frame register that a data frame is handed over now.
// Assumes: tx_done_i and adc_done_i are single-cycle pulses.
module node_seq_fsm
    import node_duty_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_i,
    input  logic              adc_done_i,
    input  logic              tx_done_i,
    input  logic              rx_irq_i,
    input  logic [ADDR_W-1:0] rx_dest_i,
    input  logic [ADDR_W-1:0] node_addr_i,
    input  logic              idle_pol_i,
    input  logic              full_pre_i,
    output node_state_e       state_o,
    output logic              take_o,
    output logic              adc_start_o,
    output logic              fwd_o,
    output logic [ADDR_W-1:0] fwd_dest_o
);

    node_state_e       st_q, st_d, rest_st;
    logic              pend_q, pend_d;
    logic              fwd_q, fwd_d;
    logic              conv_q;
    logic [ADDR_W-1:0] dest_q, dest_d;

    // Rest state chosen by the idle-versus-sleep policy.
    assign rest_st = idle_pol_i ? ST_IDLE : ST_SLEEP;

    // Next-state, wake-latch, destination and forward-flag decisions.
    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        fwd_d  = fwd_q;
        dest_d = dest_q;
        take_o = 1'b0;
        case (st_q)
            ST_SLEEP: begin
                if (wake_i || pend_q) begin
                    st_d   = ST_SENSE;
                    pend_d = 1'b0;
                end
            end
            ST_IDLE: begin
                if (wake_i || pend_q) begin
                    st_d   = ST_SENSE;
                    pend_d = 1'b0;
                end else if (rx_irq_i) begin
                    st_d   = ST_RX;
                    dest_d = rx_dest_i;
                end
            end
            ST_SENSE: begin
                if (wake_i) pend_d = 1'b1;
                if (adc_done_i) begin
                    if (full_pre_i) begin
                        st_d   = ST_TX;
                        take_o = 1'b1;
                        fwd_d  = 1'b0;
                    end else begin
                        st_d = rest_st;
                    end
                end
            end
            ST_TX: begin
                if (wake_i) pend_d = 1'b1;
                if (tx_done_i) begin
                    fwd_d = 1'b0;
                    if (full_pre_i) begin
                        take_o = 1'b1;
                    end else begin
                        st_d = rest_st;
                    end
                end
            end
            ST_RX: begin
                if (wake_i) pend_d = 1'b1;
                if (dest_q != node_addr_i) begin
                    st_d  = ST_TX;
                    fwd_d = 1'b1;
                end else begin
                    st_d = rest_st;
                end
            end
            default: st_d = ST_SLEEP;
        endcase
    end

    // State and side registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_SLEEP;
            pend_q <= 1'b0;
            fwd_q  <= 1'b0;
            conv_q <= 1'b0;
            dest_q <= '0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
            fwd_q  <= fwd_d;
            conv_q <= (st_q == ST_SENSE) && (st_d == ST_SENSE);
            dest_q <= dest_d;
        end
    end

    assign state_o     = st_q;
    assign adc_start_o = (st_q == ST_SENSE) && !conv_q;
    assign fwd_o       = fwd_q;
    assign fwd_dest_o  = dest_q;

endmodule

// File: rtl/node_frame_hold.sv
// Frame register: holds the frame handed to the radio, and its length, from the
// hand-off until the next one, so the buffer is free to refill during transmission.
// Assumes: take_i pulses only when a full window is presented.
module node_frame_hold #(
    parameter int MAX_PAYLOAD = 32,
    parameter int SAMPLE_W    = 8,
    localparam int CNT_W      = $clog2(MAX_PAYLOAD + 1),
    localparam int FRAME_W    = MAX_PAYLOAD * SAMPLE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic [FRAME_W-1:0] win_i,
    input  logic [CNT_W-1:0]   payload_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   len_o
);

    // Capture the window and the length at each hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_o <= '0;
            len_o   <= '0;
        end else if (take_i) begin
            frame_o <= win_i;
            len_o   <= payload_i;
        end
    end

endmodule

// File: rtl/node_duty_ctrl.sv
// Sensor node duty-cycle controller, top level.
// Connects the sequencer, the sample buffer and the frame register.
// All outputs are driven from registers.
// Assumes: cfg_payload_i is in 1..MAX_PAYLOAD and stays fixed while samples are buffered.
module node_duty_ctrl
    import node_duty_pkg::*;
#(
    parameter int MAX_PAYLOAD = 32,
    parameter int SAMPLE_W    = 8,
    parameter int ADDR_W      = 16,
    localparam int CNT_W      = $clog2(MAX_PAYLOAD + 1),
    localparam int FRAME_W    = MAX_PAYLOAD * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wake_tick_i,
    input  logic                adc_done_i,
    input  logic [SAMPLE_W-1:0] adc_data_i,
    input  logic                tx_done_i,
    input  logic                rx_irq_i,
    input  logic [ADDR_W-1:0]   rx_dest_i,
    input  logic [ADDR_W-1:0]   cfg_node_addr_i,
    input  logic [CNT_W-1:0]    cfg_payload_i,
    input  logic                cfg_idle_i,
    output logic [2:0]          state_o,
    output logic                adc_start_o,
    output logic                tx_req_o,
    output logic [FRAME_W-1:0]  tx_frame_o,
    output logic [CNT_W-1:0]    tx_len_o,
    output logic                fwd_req_o,
    output logic [ADDR_W-1:0]   fwd_dest_o,
    output logic                sleep_en_o
);

    node_state_e        st;
    logic               take;
    logic               full_pre;
    logic               fwd;
    logic [FRAME_W-1:0] win;

    node_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_i      (wake_tick_i),
        .adc_done_i  (adc_done_i),
        .tx_done_i   (tx_done_i),
        .rx_irq_i    (rx_irq_i),
        .rx_dest_i   (rx_dest_i),
        .node_addr_i (cfg_node_addr_i),
        .idle_pol_i  (cfg_idle_i),
        .full_pre_i  (full_pre),
        .state_o     (st),
        .take_o      (take),
        .adc_start_o (adc_start_o),
        .fwd_o       (fwd),
        .fwd_dest_o  (fwd_dest_o)
    );

    node_sample_buf #(.MAX_PAYLOAD(MAX_PAYLOAD), .SAMPLE_W(SAMPLE_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_i    (adc_done_i),
        .data_i     (adc_data_i),
        .take_i     (take),
        .payload_i  (cfg_payload_i),
        .full_pre_o (full_pre),
        .win_o      (win)
    );

    node_frame_hold #(.MAX_PAYLOAD(MAX_PAYLOAD), .SAMPLE_W(SAMPLE_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .win_i     (win),
        .payload_i (cfg_payload_i),
        .frame_o   (tx_frame_o),
        .len_o     (tx_len_o)
    );

    assign state_o    = st;
    assign tx_req_o   = (st == ST_TX);
    assign fwd_req_o  = (st == ST_TX) && fwd;
    assign sleep_en_o = (st == ST_SLEEP);

endmodule

// File: rtl/node_duty_ctrl_chk.sv
// Protocol checker for node_duty_ctrl, attached with bind.
// Assumes: inputs follow the single-cycle pulse rules stated in the brief.
module node_duty_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_done_i,
    input logic [2:0] state_o,
    input logic       adc_start_o,
    input logic       tx_req_o,
    input logic       fwd_req_o
);

    AST_STATE_CODE:   assert property (@(posedge clk) disable iff (!rst_n) state_o <= 3'd4); // R1
    AST_START_SENSE:  assert property (@(posedge clk) disable iff (!rst_n) adc_start_o |-> state_o == 3'd2); // R2
    AST_START_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) adc_start_o |=> !adc_start_o); // R2
    AST_TX_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) (state_o == 3'd3 && !tx_done_i) |=> state_o == 3'd3); // R5
    AST_SLEEP_EXIT:   assert property (@(posedge clk) disable iff (!rst_n) state_o == 3'd0 |=> (state_o == 3'd0 || state_o == 3'd2)); // R7
    AST_IDLE_EXIT:    assert property (@(posedge clk) disable iff (!rst_n) state_o == 3'd1 |=> (state_o == 3'd1 || state_o == 3'd2 || state_o == 3'd4)); // R7
    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) state_o == 3'd4 |=> state_o != 3'd4); // R8
    AST_FWD_IN_TX:    assert property (@(posedge clk) disable iff (!rst_n) fwd_req_o |-> tx_req_o); // R8

endmodule

bind node_duty_ctrl node_duty_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_done_i   (tx_done_i),
    .state_o     (state_o),
    .adc_start_o (adc_start_o),
    .tx_req_o    (tx_req_o),
    .fwd_req_o   (fwd_req_o)
);

// File: tb/node_duty_ctrl_tb.sv
`timescale 1ns/1ps
module node_duty_ctrl_tb;

    localparam int MAXP  = 32;
    localparam int SW    = 8;
    localparam int AW    = 16;
    localparam int CW    = $clog2(MAXP + 1);
    localparam int PAY   = 3;
    localparam int MYADR = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wake_tick_i = 1'b0;
    logic            adc_done_i = 1'b0;
    logic [SW-1:0]   adc_data_i = '0;
    logic            tx_done_i = 1'b0;
    logic            rx_irq_i = 1'b0;
    logic [AW-1:0]   rx_dest_i = '0;
    logic [AW-1:0]   cfg_node_addr_i = AW'(MYADR);
    logic [CW-1:0]   cfg_payload_i = CW'(PAY);
    logic            cfg_idle_i = 1'b0;
    logic [2:0]      state_o;
    logic            adc_start_o;
    logic            tx_req_o;
    logic [MAXP*SW-1:0] tx_frame_o;
    logic [CW-1:0]   tx_len_o;
    logic            fwd_req_o;
    logic [AW-1:0]   fwd_dest_o;
    logic            sleep_en_o;

    node_duty_ctrl #(.MAX_PAYLOAD(MAXP), .SAMPLE_W(SW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wake_tick_i(wake_tick_i), .adc_done_i(adc_done_i),
        .adc_data_i(adc_data_i), .tx_done_i(tx_done_i), .rx_irq_i(rx_irq_i),
        .rx_dest_i(rx_dest_i), .cfg_node_addr_i(cfg_node_addr_i),
        .cfg_payload_i(cfg_payload_i), .cfg_idle_i(cfg_idle_i), .state_o(state_o),
        .adc_start_o(adc_start_o), .tx_req_o(tx_req_o), .tx_frame_o(tx_frame_o),
        .tx_len_o(tx_len_o), .fwd_req_o(fwd_req_o), .fwd_dest_o(fwd_dest_o),
        .sleep_en_o(sleep_en_o)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Behavioural reference model
    int         ms = 0;
    logic [7:0] mq[$];
    bit         mpend = 0, mfwd = 0, mconv = 0, mvalid = 0;
    int         mdest = 0;
    int         mlen = 0;
    int         mframe[MAXP];

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mq.delete(); mpend = 0; mfwd = 0; mconv = 0; mdest = 0; mlen = 0;
            for (int i = 0; i < MAXP; i++) mframe[i] = 0;
            mvalid = 1;
        end else begin
            int  ns;
            int  rest;
            bit  take;
            bit  full;
            ns = ms; take = 0;
            rest = cfg_idle_i ? 1 : 0;
            if (adc_done_i) begin
                mq.push_back(adc_data_i);
                while (mq.size() > PAY) void'(mq.pop_front());
            end
            full = (mq.size() >= PAY);
            case (ms)
                0: if (wake_tick_i || mpend) begin ns = 2; mpend = 0; end
                1: if (wake_tick_i || mpend) begin ns = 2; mpend = 0; end
                   else if (rx_irq_i) begin ns = 4; mdest = int'(rx_dest_i); end
                2: begin
                    if (wake_tick_i) mpend = 1;
                    if (adc_done_i) begin
                        if (full) begin ns = 3; take = 1; mfwd = 0; end else ns = rest;
                    end
                end
                3: begin
                    if (wake_tick_i) mpend = 1;
                    if (tx_done_i) begin
                        mfwd = 0;
                        if (full) take = 1; else ns = rest;
                    end
                end
                default: begin
                    if (wake_tick_i) mpend = 1;
                    if (mdest != MYADR) begin ns = 3; mfwd = 1; end else ns = rest;
                end
            endcase
            if (take) begin
                for (int i = 0; i < MAXP; i++) mframe[i] = (i < mq.size()) ? int'(mq[i]) : 0;
                mlen = PAY;
                mq.delete();
            end
            mconv = (ms == 2 && ns == 2);
            ms = ns;
        end
    end

    // Cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (mvalid && rst_n && !done) begin
            chk("R1 state trace", int'(state_o), ms);
            chk("R2 adc start", int'(adc_start_o), int'(ms == 2 && !mconv));
            chk("R5 tx request", int'(tx_req_o), int'(ms == 3));
            chk("R8 forward request", int'(fwd_req_o), int'(ms == 3 && mfwd));
            chk("R11 sleep enable", int'(sleep_en_o), int'(ms == 0));
            if (ms == 3 && mfwd) chk("R8 forward dest", int'(fwd_dest_o), mdest);
            if (ms == 3 && !mfwd) begin
                chk("R4 frame length", int'(tx_len_o), mlen);
                for (int k = 0; k < PAY; k++)
                    chk("R4 frame byte", int'(tx_frame_o[k*SW +: SW]), mframe[k]);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            finish_run();
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sample(logic [7:0] d);
        wake_tick_i = 1'b1; step(1); wake_tick_i = 1'b0;
        for (int i = 0; i < 20 && !adc_start_o; i++) step(1);
        step(2);
        adc_done_i = 1'b1; adc_data_i = d; step(1); adc_done_i = 1'b0;
    endtask

    task automatic pulse_done();
        tx_done_i = 1'b1; step(1); tx_done_i = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 reset state", int'(state_o), 0);
        chk("R11 reset sleep", int'(sleep_en_o), 1);

        sample(8'h11);
        chk("R3 below payload to SLEEP", int'(state_o), 0);
        cfg_idle_i = 1'b1;
        sample(8'h22);
        chk("R3 below payload to IDLE", int'(state_o), 1);
        chk("R11 idle not sleeping", int'(sleep_en_o), 0);

        sample(8'h33);
        chk("R4 full payload to TX", int'(state_o), 3);
        chk("R4 length", int'(tx_len_o), PAY);
        chk("R4 oldest byte", int'(tx_frame_o[7:0]), 'h11);
        chk("R4 newest byte", int'(tx_frame_o[23:16]), 'h33);
        step(5);
        chk("R5 held in TX", int'(tx_req_o), 1);

        wake_tick_i = 1'b1; step(1); wake_tick_i = 1'b0;
        chk("R10 wake in TX latched", int'(state_o), 3);
        adc_done_i = 1'b1;
        adc_data_i = 8'h44; step(1);
        adc_data_i = 8'h55; step(1);
        adc_data_i = 8'h66; step(1);
        adc_data_i = 8'h77; step(1);
        adc_done_i = 1'b0;
        pulse_done();
        chk("R6 back-to-back TX", int'(state_o), 3);
        chk("R9 oldest discarded", int'(tx_frame_o[7:0]), 'h55);
        chk("R9 newest kept", int'(tx_frame_o[23:16]), 'h77);
        pulse_done();
        chk("R6 TX exit to IDLE", int'(state_o), 1);
        step(1);
        chk("R10 latched wake serviced", int'(state_o), 2);
        step(1);
        adc_done_i = 1'b1; adc_data_i = 8'h88; step(1); adc_done_i = 1'b0;
        chk("R3 back to IDLE", int'(state_o), 1);

        rx_irq_i = 1'b1; rx_dest_i = AW'(MYADR); step(1); rx_irq_i = 1'b0;
        chk("R7 IDLE to RX", int'(state_o), 4);
        step(1);
        chk("R8 own frame consumed", int'(state_o), 1);
        rx_irq_i = 1'b1; rx_dest_i = AW'(7); step(1); rx_irq_i = 1'b0;
        step(1);
        chk("R8 foreign frame to TX", int'(state_o), 3);
        chk("R8 forward flag", int'(fwd_req_o), 1);
        chk("R8 forward dest", int'(fwd_dest_o), 7);
        step(2);
        pulse_done();
        chk("R8 forward done", int'(state_o), 1);

        cfg_idle_i = 1'b0;
        sample(8'h99);
        chk("R3 to SLEEP with two buffered", int'(state_o), 0);
        rx_irq_i = 1'b1; rx_dest_i = AW'(7); step(3); rx_irq_i = 1'b0;
        chk("R7 receive ignored in SLEEP", int'(state_o), 0);
        sample(8'hAA);
        chk("R4 second frame", int'(state_o), 3);
        chk("R4 frame oldest", int'(tx_frame_o[7:0]), 'h88);
        chk("R4 frame middle", int'(tx_frame_o[15:8]), 'h99);
        step(2);
        pulse_done();
        chk("R6 TX exit to SLEEP", int'(state_o), 0);
        step(3);
        finish_run();
    end

endmodule